// File: doc/BRIEF.md
# Reset-Time Memory Fill Sequencer

This block sits beside an on-chip memory array and gives it defined contents after every reset. Once reset is released, it samples a fill policy, a pattern byte, a seed and a word count. It then walks the array from word 0 upward and writes one full 32-bit word per clock. After that it marks the memory ready and lets the normal bus port through. Until then the bus port is stalled and sees no acknowledge.

Five mode codes are accepted:
- **Untouched:** no writes are made.
- **Constant byte:** every byte receives the pattern byte.
- **Zero:** the constant-byte mode with the byte forced to 0x00.
- **Seeded pseudo-random bytes:** each byte receives the next output of a 32-bit LFSR.
- **Exit instruction:** every word receives a fixed trap/exit instruction word.

Any other code is a configuration error.

Byte offset 0 of a word is bit field [31:24] throughout (big-endian). The reset input is asynchronous and active low. It is released through a two-stage synchronizer, so the first write appears on the third rising clock edge after `rst_n` rises.

Top module: `memfill_seq`

## Requirements
- R1: While `rst_n` is low and until the fill completes, `busy`=1, `done`=0 and `wr_en`=0, except in the write cycles of R2.
- R2: With an active mode and N = `word_count` > 0, `wr_en`=1 for exactly N consecutive cycles, starting at the third rising edge after `rst_n` rises. In those cycles `wr_addr` runs 0,1,...,N-1 and `wr_be`=4'hF.
- R3: `done` rises and `busy` falls in the cycle after the last write. Both then hold until the next reset.
- R4: Mode code 0 (untouched), or `word_count`=0 with any valid mode, makes no write. `done` rises at the third rising edge after release.
- R5: Mode code 1 (constant) writes `{4{fill_byte[7:0]}}`; bits [15:8] of `fill_byte` have no effect.
- R6: Mode code 4 (zero) writes 32'h00000000 whatever `fill_byte` is.
- R7: Mode code 2 (random) uses a Galois right-shift LFSR. One step is `s = s[0] ? (s>>1) ^ 32'h80200003 : s>>1`. The byte at offset k of word w (offset 0 in [31:24]) is bits [7:0] of the state after 4w+k+1 steps from the seed.
- R8: In random mode a seed of 0 is replaced by 32'hACE12468.
- R9: Mode code 3 (exit) writes 32'h15000001 to every word, that is 0x15,0x00,0x00,0x01 at offsets 0..3.
- R10: Mode codes 5, 6 and 7 set `cfg_err`=1 at the third rising edge after release. They make no write, and `busy`=0 and `done`=0 from then on.
- R11: `bus_ack` = `bus_req` & `done` and `bus_stall` = `bus_req` & ~`done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_mode | input | 3 | Fill policy code, sampled once after reset |
| fill_byte | input | 16 | Pattern value; only [7:0] is used |
| fill_seed | input | 32 | Random-mode seed |
| word_count | input | ADDR_W+1 | Words to fill; clamped to 2^ADDR_W |
| bus_req | input | 1 | Normal bus port request |
| bus_ack | output | 1 | Normal bus port acknowledge |
| bus_stall | output | 1 | Normal bus port held off |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | ADDR_W | Array word address |
| wr_data | output | 32 | Array write word |
| wr_be | output | 4 | Byte enables |
| busy | output | 1 | Fill in progress |
| done | output | 1 | Memory released |
| cfg_err | output | 1 | Invalid mode code |

## Verification
The bench builds the block with ADDR_W=4, so the array holds 16 words. A full-depth exit fill therefore reaches the last address and the counter limit within a few dozen cycles. Each reset starts a new run, so every mode, a zero seed, a zero word count, a truncated pattern value and an invalid code each get their own short run. Every run is compared cycle by cycle against a behavioural model.

// File: rtl/memfill_pkg.sv
package memfill_pkg;
  localparam logic [2:0] MODE_NONE = 3'd0;
  localparam logic [2:0] MODE_PAT  = 3'd1;
  localparam logic [2:0] MODE_RAND = 3'd2;
  localparam logic [2:0] MODE_EXIT = 3'd3;
  localparam logic [2:0] MODE_ZERO = 3'd4;

  localparam logic [31:0] LFSR_MASK = 32'h80200003;
  localparam logic [31:0] SEED_SUB  = 32'hACE12468;
  localparam logic [31:0] EXIT_WORD = 32'h15000001;

  typedef enum logic [1:0] {ST_START, ST_FILL, ST_DONE, ST_ERR} fill_state_e;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction

  function automatic logic mode_valid(input logic [2:0] m);
    return m <= MODE_ZERO;
  endfunction
endpackage

// File: rtl/memfill_ctrl.sv
module memfill_ctrl import memfill_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_in,
  input  logic [ADDR_W:0]   count_in,
  output logic              load,
  output logic              adv,
  output logic [2:0]        mode_q,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

  fill_state_e       state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W:0]   lim_q, lim_d;
  logic [2:0]        mode_d;
  logic              last;

  assign load = (state_q == ST_START);
  assign adv  = (state_q == ST_FILL);
  assign last = (({1'b0, cnt_q} + 1'b1) == lim_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    mode_d  = mode_q;
    case (state_q)
      ST_START: begin
        mode_d = mode_in;
        lim_d  = (count_in > DEPTH) ? DEPTH : count_in;
        cnt_d  = '0;
        if (!mode_valid(mode_in))                      state_d = ST_ERR;
        else if (mode_in == MODE_NONE || count_in == '0) state_d = ST_DONE;
        else                                            state_d = ST_FILL;
      end
      ST_FILL: begin
        cnt_d = cnt_q + 1'b1;
        if (last) state_d = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      lim_q   <= '0;
      mode_q  <= MODE_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      mode_q  <= mode_d;
    end
  end

  assign addr = cnt_q;
  assign busy = (state_q == ST_START) || (state_q == ST_FILL);
  assign done = (state_q == ST_DONE);
  assign err  = (state_q == ST_ERR);
endmodule

// File: rtl/memfill_lfsr.sv
module memfill_lfsr import memfill_pkg::*; #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic [31:0]        seed,
  output logic [8*BYTES-1:0] rand_word
);
  logic [31:0] state_q, state_d;
  logic [31:0] chain [BYTES+1];

  assign chain[0] = state_q;
  for (genvar k = 0; k < BYTES; k++) begin : g_step
    assign chain[k+1] = lfsr_step(chain[k]);
    assign rand_word[8*(BYTES-k)-1 -: 8] = chain[k+1][7:0];
  end

  always_comb begin
    state_d = state_q;
    if (load)     state_d = (seed == '0) ? SEED_SUB : seed;
    else if (adv) state_d = chain[BYTES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED_SUB;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/memfill_datagen.sv
module memfill_datagen import memfill_pkg::*; #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] pat_in,
  input  logic [2:0]       mode_q,
  input  logic [31:0]      rand_word,
  output logic [31:0]      data
);
  logic [7:0] pat_q, pat_d;
  logic       unused_pat_hi;

  assign unused_pat_hi = ^pat_in[PAT_W-1:8];

  always_comb begin
    pat_d = pat_q;
    if (load) pat_d = pat_in[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_q <= '0;
    else        pat_q <= pat_d;
  end

  always_comb begin
    case (mode_q)
      MODE_PAT:  data = {4{pat_q}};
      MODE_RAND: data = rand_word;
      MODE_EXIT: data = EXIT_WORD;
      default:   data = '0;
    endcase
  end
endmodule

// File: rtl/memfill_seq.sv
module memfill_seq import memfill_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int PAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fill_mode,
  input  logic [PAT_W-1:0]  fill_byte,
  input  logic [31:0]       fill_seed,
  input  logic [ADDR_W:0]   word_count,
  input  logic              bus_req,
  output logic              bus_ack,
  output logic              bus_stall,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  logic       sync1_q, rst_i;
  logic       load, adv;
  logic [2:0] mode_q;
  logic [31:0] rand_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_i   <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_i   <= sync1_q;
    end
  end

  memfill_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .mode_in(fill_mode), .count_in(word_count),
    .load(load), .adv(adv), .mode_q(mode_q), .addr(wr_addr),
    .busy(busy), .done(done), .err(cfg_err)
  );

  memfill_lfsr #(.BYTES(4)) u_lfsr (
    .clk(clk), .rst_n(rst_i), .load(load), .adv(adv),
    .seed(fill_seed), .rand_word(rand_word)
  );

  memfill_datagen #(.PAT_W(PAT_W)) u_data (
    .clk(clk), .rst_n(rst_i), .load(load), .pat_in(fill_byte),
    .mode_q(mode_q), .rand_word(rand_word), .data(wr_data)
  );

  assign wr_en     = adv;
  assign wr_be     = {4{adv}};
  assign bus_ack   = bus_req & done;
  assign bus_stall = bus_req & ~done;
endmodule

// File: rtl/memfill_chk.sv
module memfill_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [3:0]        wr_be,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [2:0]        mode_q
);
  // R1
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy && !done);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));
  // R2
  full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_be == 4'hF);
  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !busy);
  // R9
  exit_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode_q == 3'd3 |-> wr_data == 32'h15000001);
  // R6
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode_q == 3'd4 |-> wr_data == 32'h0);
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !done && !busy && !wr_en);
  // R11
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> done && bus_req);
endmodule

bind memfill_seq memfill_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_be(wr_be), .busy(busy), .done(done),
  .cfg_err(cfg_err), .bus_req(bus_req), .bus_ack(bus_ack), .mode_q(mode_q)
);

// File: tb/sim_memfill_seq.sv
`timescale 1ns/1ps
module sim_memfill_seq;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    fill_mode;
  logic [15:0]   fill_byte;
  logic [31:0]   fill_seed;
  logic [AW:0]   word_count;
  logic          bus_req;
  logic          bus_ack, bus_stall, wr_en, busy, done, cfg_err;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [3:0]    wr_be;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  memfill_seq #(.ADDR_W(AW), .PAT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_mode(fill_mode), .fill_byte(fill_byte),
    .fill_seed(fill_seed), .word_count(word_count), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_stall(bus_stall), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_step(input logic [31:0] s);
    logic [31:0] r = s >> 1;
    if (s[0]) r = r ^ 32'h80200003;
    return r;
  endfunction

  task automatic run(input logic [2:0] m, input logic [15:0] pat,
                     input logic [31:0] seed, input int n, input string tag);
    logic [31:0] ms;
    logic [31:0] exp_data;
    bit valid, active;
    int cyc;
    valid  = (m <= 3'd4);
    active = valid && m != 3'd0 && n > 0;
    ms = (seed == 0) ? 32'hACE12468 : seed;
    @(negedge clk);
    rst_n = 1'b0;
    fill_mode = m; fill_byte = pat; fill_seed = seed;
    word_count = (AW+1)'(n); bus_req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({tag, " R1 reset wr_en"}, {31'b0, wr_en}, 32'd0);
    chk({tag, " R1 reset done"},  {31'b0, done},  32'd0);
    chk({tag, " R1 reset busy"},  {31'b0, busy},  32'd1);
    chk({tag, " R11 reset stall"}, {31'b0, bus_stall}, 32'd1);
    rst_n = 1'b1;
    for (cyc = 1; cyc <= 3 + n + 4; cyc++) begin
      bit e_wr, e_done, e_busy, e_err;
      @(posedge clk); @(negedge clk);
      e_wr   = active && cyc >= 3 && cyc < 3 + n;
      e_done = valid && cyc >= 3 + (active ? n : 0);
      e_err  = !valid && cyc >= 3;
      e_busy = !e_done && !e_err;
      chk({tag, " R2 wr_en"}, {31'b0, wr_en}, {31'b0, e_wr});
      chk({tag, " R3 done"},  {31'b0, done},  {31'b0, e_done});
      chk({tag, " R1 busy"},  {31'b0, busy},  {31'b0, e_busy});
      chk({tag, " R10 cfg_err"}, {31'b0, cfg_err}, {31'b0, e_err});
      chk({tag, " R11 bus_ack"}, {31'b0, bus_ack}, {31'b0, e_done});
      chk({tag, " R11 bus_stall"}, {31'b0, bus_stall}, {31'b0, !e_done});
      if (e_wr) begin
        chk({tag, " R2 wr_addr"}, 32'(wr_addr), 32'(cyc - 3));
        chk({tag, " R2 wr_be"},   32'(wr_be), 32'hF);
        case (m)
          3'd1: exp_data = {4{pat[7:0]}};
          3'd2: begin
            for (int k = 0; k < 4; k++) begin
              ms = ref_step(ms);
              exp_data[31-8*k -: 8] = ms[7:0];
            end
          end
          3'd3: exp_data = 32'h15000001;
          default: exp_data = 32'h0;
        endcase
        chk({tag, (m == 3'd2) ? " R7 R8 wr_data" :
                  (m == 3'd3) ? " R9 wr_data" :
                  (m == 3'd4) ? " R6 wr_data" : " R5 wr_data"},
            wr_data, exp_data);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; fill_mode = 3'd0; fill_byte = '0; fill_seed = '0;
    word_count = '0; bus_req = 1'b0;
    run(3'd1, 16'h01A5, 32'h0, 5,  "pattern_trunc");
    run(3'd1, 16'hFF3C, 32'h0, 2,  "pattern_3c");
    run(3'd2, 16'h0000, 32'h12345678, 6, "random_seed");
    run(3'd2, 16'h0000, 32'h0, 3,  "random_zero_seed");
    run(3'd3, 16'h00AA, 32'h0, 16, "exit_full");
    run(3'd4, 16'h00EE, 32'h0, 4,  "zero_mode");
    run(3'd0, 16'h0055, 32'h0, 5,  "R4 untouched");
    run(3'd1, 16'h0055, 32'h0, 0,  "R4 zero_count");
    run(3'd6, 16'h0055, 32'h0, 5,  "invalid_6");
    run(3'd7, 16'h0055, 32'h0, 5,  "invalid_7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule